// File: doc/BRIEF.md
# Divisor Range Prescaler

This block takes a normalized fixed-point divisor `y` (one integer bit, value in [1, 2)) and multiplies it by a short factor `M` so that the product lands close to one, within [7/8, 9/8). A digit-recurrence divider that selects its quotient digits by rounding needs a divisor near one. This block provides that first coarse step without a lookup of `M` from a table and without a multiplier. The three fraction bits right after the integer bit place `y` in one of eight sub-intervals of width 1/8. Each sub-interval fixes up to three addends taken from {y, y/2, y/4, y/8, −y/8, 0}. The addends are reduced by a 3-to-2 carry-save stage and one final adder.

The product is exact: it carries three more fraction bits than the input, so nothing is rounded. Next to the scaled divisor, the block returns the factor `M` in eighths and the three addend codes. A dividend path can then apply the same factor with the same shift-add structure. The result is registered, with a latency of one cycle, and is held between requests.

Top module: `divisor_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero: `valid_o`, `scaled_o`, `scale_o` and `sel_o`.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high at the clock edge, and low otherwise.
- R3: The bin is `y_i[DIV_W-2:DIV_W-4]`. `scale_o` is a 4-bit unsigned factor in units of 1/8, set per bin as follows: bin 0 gives 8, bin 1 gives 7, bins 2–3 give 6, bins 4–5 give 5, bins 6–7 give 4.
- R4: `sel_o` packs three 3-bit addend codes, with slot 0 in bits [2:0], slot 1 in [5:3] and slot 2 in [8:6]. The codes are 0 for zero, 1 for y, 2 for y/2, 3 for y/4, 4 for y/8 and 5 for −y/8. Per bin, the slot codes (slot 2, slot 1, slot 0) are: bin 0 (0,0,1), bin 1 (0,5,1), bins 2–3 (0,3,2), bins 4–5 (0,4,2), bins 6–7 (0,0,2). The weighted sum of the codes equals `scale_o`.
- R5: `scaled_o` has one integer bit and `DIV_W+2` fraction bits. As an integer it equals `scale_o × y_i` exactly, with no rounding.
- R6: For every `y_i` with its top bit set, `scaled_o` is at least 7/8 and below 9/8. It equals 7/8 only for y = 1.75 and is strictly above 7/8 for every other input.
- R7: In a cycle with `valid_i` low, `scaled_o`, `scale_o` and `sel_o` keep their values, whatever `y_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe; `y_i` is captured when high |
| y_i | input | DIV_W | Divisor, 1 integer bit and DIV_W-1 fraction bits, top bit set |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| scaled_o | output | DIV_W+3 | Scaled divisor M·y, 1 integer bit, DIV_W+2 fraction bits |
| scale_o | output | 4 | Factor M in eighths (4 to 8) |
| sel_o | output | 9 | Three packed 3-bit addend codes |

## Verification
The checker assumes that every accepted divisor is normalized, with its top bit set. An input below one lies outside all eight bins and gives no range guarantee. It also assumes that `valid_i` is low while reset is applied, because the latency property compares against the strobe of the previous cycle. The bench only ever forms divisors by OR-ing the integer bit with a bin index and low bits, and holds `valid_i` low throughout reset. Stimulus covers both edges of every bin, a random fill of low bits per bin, and the y = 1.75 point, which is the one point where the lower bound is reached.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

    localparam int SLOT_N = 3;
    localparam int CODE_W = 3;
    localparam int BIN_W  = 3;
    localparam int SCALE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        ADD_ZERO  = 3'd0,
        ADD_Y1    = 3'd1,
        ADD_Y2    = 3'd2,
        ADD_Y4    = 3'd3,
        ADD_Y8    = 3'd4,
        ADD_NEGY8 = 3'd5
    } addend_e;

    typedef struct packed {
        addend_e s2;
        addend_e s1;
        addend_e s0;
    } addend_set_t;

    // Weight of one addend in units of 1/8.
    function automatic int code_weight(logic [CODE_W-1:0] code);
        case (code)
            ADD_Y1:    return 8;
            ADD_Y2:    return 4;
            ADD_Y4:    return 2;
            ADD_Y8:    return 1;
            ADD_NEGY8: return -1;
            default:   return 0;
        endcase
    endfunction

    // Addend choice per bin of width 1/8 above one.
    function automatic addend_set_t pick_set(logic [BIN_W-1:0] bin);
        addend_set_t s;
        s = '{s2: ADD_ZERO, s1: ADD_ZERO, s0: ADD_Y2};
        case (bin)
            3'd0: s = '{s2: ADD_ZERO, s1: ADD_ZERO,  s0: ADD_Y1};
            3'd1: s = '{s2: ADD_ZERO, s1: ADD_NEGY8, s0: ADD_Y1};
            3'd2,
            3'd3: s = '{s2: ADD_ZERO, s1: ADD_Y4,    s0: ADD_Y2};
            3'd4,
            3'd5: s = '{s2: ADD_ZERO, s1: ADD_Y8,    s0: ADD_Y2};
            default: s = '{s2: ADD_ZERO, s1: ADD_ZERO, s0: ADD_Y2};
        endcase
        return s;
    endfunction

    function automatic logic [SCALE_W-1:0] set_scale(addend_set_t s);
        int acc;
        acc = code_weight(s.s0) + code_weight(s.s1) + code_weight(s.s2);
        return SCALE_W'(acc);
    endfunction

endpackage

// File: rtl/prescale_select.sv
module prescale_select
    import prescale_pkg::*;
(
    input  logic [BIN_W-1:0]   bin_i,
    output addend_set_t        set_o,
    output logic [SCALE_W-1:0] scale_o
);
    always_comb begin
        set_o   = pick_set(bin_i);
        scale_o = set_scale(set_o);
    end
endmodule

// File: rtl/prescale_term.sv
module prescale_term
    import prescale_pkg::*;
#(
    parameter int DIV_W = 16,
    localparam int OW   = DIV_W + 3
) (
    input  logic [DIV_W-1:0] y_i,
    input  addend_e          code_i,
    output logic [OW-1:0]    term_o
);
    logic [OW-1:0] y_ext;

    always_comb begin
        y_ext = {y_i, 3'b000};
        case (code_i)
            ADD_Y1:    term_o = y_ext;
            ADD_Y2:    term_o = y_ext >> 1;
            ADD_Y4:    term_o = y_ext >> 2;
            ADD_Y8:    term_o = y_ext >> 3;
            ADD_NEGY8: term_o = ~(y_ext >> 3) + OW'(1);
            default:   term_o = '0;
        endcase
    end
endmodule

// File: rtl/prescale_csa.sv
module prescale_csa #(
    parameter int W = 19
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    assign sum_o      = a_i ^ b_i ^ c_i;
    assign carry_o[0] = 1'b0;

    for (genvar i = 0; i < W - 1; i++) begin : g_maj
        assign carry_o[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
    end
endmodule

// File: rtl/divisor_prescaler.sv
module divisor_prescaler
    import prescale_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      valid_i,
    input  logic [DIV_W-1:0]          y_i,
    output logic                      valid_o,
    output logic [DIV_W+2:0]          scaled_o,
    output logic [SCALE_W-1:0]        scale_o,
    output logic [SLOT_N*CODE_W-1:0]  sel_o
);
    localparam int OW = DIV_W + 3;

    addend_set_t          set_w;
    logic [SCALE_W-1:0]   scale_w;
    addend_e              code_w [SLOT_N];
    logic [OW-1:0]        term_w [SLOT_N];
    logic [OW-1:0]        cs_sum;
    logic [OW-1:0]        cs_carry;
    logic [OW-1:0]        total_w;

    prescale_select u_sel (
        .bin_i   (y_i[DIV_W-2 -: BIN_W]),
        .set_o   (set_w),
        .scale_o (scale_w)
    );

    assign code_w[0] = set_w.s0;
    assign code_w[1] = set_w.s1;
    assign code_w[2] = set_w.s2;

    for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
        prescale_term #(.DIV_W(DIV_W)) u_term (
            .y_i    (y_i),
            .code_i (code_w[k]),
            .term_o (term_w[k])
        );
    end

    prescale_csa #(.W(OW)) u_csa (
        .a_i     (term_w[0]),
        .b_i     (term_w[1]),
        .c_i     (term_w[2]),
        .sum_o   (cs_sum),
        .carry_o (cs_carry)
    );

    // Modulo-2^OW add; the true product lies in [0, 2) so it is exact.
    assign total_w = cs_sum + cs_carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            scaled_o <= '0;
            scale_o  <= '0;
            sel_o    <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                scaled_o <= total_w;
                scale_o  <= scale_w;
                sel_o    <= set_w;
            end
        end
    end
endmodule

// File: rtl/prescale_chk.sv
module prescale_chk
    import prescale_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     valid_i,
    input logic [DIV_W-1:0]         y_i,
    input logic                     valid_o,
    input logic [DIV_W+2:0]         scaled_o,
    input logic [SCALE_W-1:0]       scale_o,
    input logic [SLOT_N*CODE_W-1:0] sel_o
);
    localparam int OW = DIV_W + 3;
    localparam int OF = DIV_W + 2;
    localparam logic [OW-1:0] LO_BOUND = OW'(7) << (OF - 3);
    localparam logic [OW-1:0] HI_BOUND = OW'(9) << (OF - 3);
    localparam logic [DIV_W-1:0] Y_175 = DIV_W'(7) << (DIV_W - 3);

    logic             live_q;
    logic [DIV_W-1:0] y_q;
    logic [OW:0]      prod;
    int               wsum;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            y_q    <= '0;
        end else begin
            live_q <= 1'b1;
            if (valid_i) y_q <= y_i;
        end
    end

    always_comb begin
        prod = (OW+1)'(y_q) * (OW+1)'(scale_o);
        wsum = code_weight(sel_o[2:0]) + code_weight(sel_o[5:3]) + code_weight(sel_o[8:6]);
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (valid_o == $past(valid_i)));

    // R3
    scale_legal_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (scale_o >= 4'd4 && scale_o <= 4'd8));

    // R4
    code_sum_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (wsum == int'(scale_o)));

    // R5
    exact_product_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ({1'b0, scaled_o} == prod));

    // R6
    range_low_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (scaled_o >= LO_BOUND));

    // R6
    range_high_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (scaled_o < HI_BOUND));

    // R6
    floor_point_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && scaled_o == LO_BOUND) |-> (y_q == Y_175));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(valid_i)) |-> ($stable(scaled_o) && $stable(scale_o) && $stable(sel_o)));
endmodule

bind divisor_prescaler prescale_chk #(.DIV_W(DIV_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .y_i      (y_i),
    .valid_o  (valid_o),
    .scaled_o (scaled_o),
    .scale_o  (scale_o),
    .sel_o    (sel_o)
);

// File: tb/divisor_prescaler_tb_top.sv
`timescale 1ns/1ps
module divisor_prescaler_tb_top;
    localparam int DIV_W = 16;
    localparam int OW    = DIV_W + 3;
    localparam logic [OW-1:0] LO_B = 19'h38000;
    localparam logic [OW-1:0] HI_B = 19'h48000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             valid_i = 1'b0;
    logic [DIV_W-1:0] y_i = '0;
    logic             valid_o;
    logic [OW-1:0]    scaled_o;
    logic [3:0]       scale_o;
    logic [8:0]       sel_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    divisor_prescaler #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .y_i(y_i),
        .valid_o(valid_o), .scaled_o(scaled_o), .scale_o(scale_o), .sel_o(sel_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_scale(logic [DIV_W-1:0] y);
        case (y[DIV_W-2 -: 3])
            3'd0: return 4'd8;
            3'd1: return 4'd7;
            3'd2, 3'd3: return 4'd6;
            3'd4, 3'd5: return 4'd5;
            default: return 4'd4;
        endcase
    endfunction

    function automatic logic [8:0] exp_sel(logic [DIV_W-1:0] y);
        case (y[DIV_W-2 -: 3])
            3'd0: return {3'd0, 3'd0, 3'd1};
            3'd1: return {3'd0, 3'd5, 3'd1};
            3'd2, 3'd3: return {3'd0, 3'd3, 3'd2};
            3'd4, 3'd5: return {3'd0, 3'd4, 3'd2};
            default: return {3'd0, 3'd0, 3'd2};
        endcase
    endfunction

    // Drive one request, sample one cycle later away from the edge.
    task automatic apply_and_check(input logic [DIV_W-1:0] y);
        logic [OW:0] want;
        @(negedge clk);
        valid_i = 1'b1;
        y_i     = y;
        @(negedge clk);
        valid_i = 1'b0;
        want = (OW+1)'(y) * (OW+1)'(exp_scale(y));
        chk(valid_o == 1'b1, "R2 valid_o", 32'(valid_o), 32'd1);
        chk(scale_o == exp_scale(y), "R3 scale_o", 32'(scale_o), 32'(exp_scale(y)));
        chk(sel_o == exp_sel(y), "R4 sel_o", 32'(sel_o), 32'(exp_sel(y)));
        chk({1'b0, scaled_o} == want, "R5 scaled_o", 32'(scaled_o), 32'(want));
        chk(scaled_o >= LO_B && scaled_o < HI_B, "R6 range", 32'(scaled_o), 32'(LO_B));
        if (y != 16'hE000)
            chk(scaled_o > LO_B, "R6 strict lower", 32'(scaled_o), 32'(LO_B));
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(valid_o == 1'b0, "R1 valid_o", 32'(valid_o), 32'd0);
        chk(scaled_o == '0, "R1 scaled_o", 32'(scaled_o), 32'd0);
        chk(scale_o == '0, "R1 scale_o", 32'(scale_o), 32'd0);
        chk(sel_o == '0, "R1 sel_o", 32'(sel_o), 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_bin_edges;
        for (int k = 0; k < 8; k++) begin
            apply_and_check(16'h8000 | 16'(k << 12));
            apply_and_check(16'h8000 | 16'(k << 12) | 16'h0FFF);
        end
    endtask

    task automatic t_random_fill;
        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 24; n++) begin
                apply_and_check(16'h8000 | 16'(k << 12) | 16'($urandom() & 32'h0FFF));
            end
        end
    endtask

    task automatic t_floor_point;
        // R6: 1.75 reaches 7/8 exactly; the next code lies strictly above
        apply_and_check(16'hE000);
        chk(scaled_o == LO_B, "R6 floor equals 7/8", 32'(scaled_o), 32'(LO_B));
        apply_and_check(16'hE001);
        apply_and_check(16'hFFFF);
        apply_and_check(16'h8000);
    endtask

    task automatic t_latency;
        apply_and_check(16'h9A5C);
        @(negedge clk);
        chk(valid_o == 1'b0, "R2 valid_o drop", 32'(valid_o), 32'd0);
        @(negedge clk);
        valid_i = 1'b1; y_i = 16'hC123;
        @(negedge clk);
        y_i = 16'hA777;
        @(negedge clk);
        valid_i = 1'b0;
        chk(valid_o == 1'b1, "R2 back-to-back", 32'(valid_o), 32'd1);
        chk(scale_o == 4'd6, "R3 back-to-back scale", 32'(scale_o), 32'd6);
        @(negedge clk);
        chk(valid_o == 1'b0, "R2 valid_o drop after burst", 32'(valid_o), 32'd0);
    endtask

    task automatic t_hold;
        logic [OW-1:0] s0;
        logic [3:0]    m0;
        logic [8:0]    c0;
        apply_and_check(16'h9000);
        s0 = scaled_o; m0 = scale_o; c0 = sel_o;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            y_i = 16'hF000 | 16'(n);
            @(negedge clk);
            chk(scaled_o == s0, "R7 scaled_o held", 32'(scaled_o), 32'(s0));
            chk(scale_o == m0, "R7 scale_o held", 32'(scale_o), 32'(m0));
            chk(sel_o == c0, "R7 sel_o held", 32'(sel_o), 32'(c0));
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_bin_edges();
        t_random_fill();
        t_floor_point();
        t_latency();
        t_hold();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            finish_run();
        end
    end
endmodule